// File: doc/BRIEF.md
# Refresh-Qualified DMA Acknowledge Filter

This block sits beside the bus-master engine of an expansion-bus peripheral. It watches three asynchronous bus inputs: the memory refresh indicator, the memory read strobe and the DMA acknowledge. From them it produces a qualified acknowledge that the master logic may use to begin a transfer. An acknowledge that is first seen while a refresh is in progress is treated as false, and it stays blocked until it releases, even if the refresh ends first. Some motherboards produce such spurious acknowledges during refresh. Only a fresh acknowledge edge that occurs outside refresh is passed on.

The block also follows each refresh through its phases. These are refresh asserted, strobe asserted, strobe released and refresh released. A read strobe that belongs to a refresh is therefore never reported as ordinary memory activity. Each completed refresh strobe gives a one-cycle pulse and advances a wrapping counter. When bus-master operation is disabled, the qualified acknowledge is forced low and any pending suppression is discarded. All inputs pass through two-stage synchronisers, and the whole block runs on one clock.

Top module: `dma_ack_filter`

## Requirements
- R1: While reset is held and after it is released with idle inputs, dack_ok, memr_ok, in_refresh and refresh_seen are 0 and refresh_count is 0.
- R2: With master_en high and ref_in low, dack_ok follows dack_in with a latency of exactly three rising clock edges, both on assertion and on release.
- R3: A dack_in that rises while ref_in is high never produces dack_ok. This holds through the refresh and after ref_in falls, for as long as dack_in stays high.
- R4: If ref_in rises while dack_ok is high, dack_ok drops three edges later. It stays low after ref_in falls until dack_in has been released.
- R5: After a suppressed acknowledge releases, the next dack_in assertion outside refresh produces dack_ok again.
- R6: With master_en low, dack_ok is 0 one edge later and any suppression is cleared. Re-enabling with dack_in still high and ref_in low gives dack_ok = 1 one edge later.
- R7: in_refresh rises three edges after ref_in rises and falls three edges after ref_in falls.
- R8: A memr_in pulse inside a refresh raises refresh_seen for exactly one cycle, three edges after memr_in falls. In that same cycle refresh_count increments by one (modulo 2^CNT_W).
- R9: memr_ok is never 1 for a strobe inside a refresh. Outside refresh it follows memr_in with a latency of three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_en | input | 1 | Bus-master operation enabled (synchronous to clk) |
| ref_in | input | 1 | Memory refresh indicator, active high, asynchronous |
| memr_in | input | 1 | Memory read strobe, active high, asynchronous |
| dack_in | input | 1 | DMA acknowledge, active high, asynchronous |
| dack_ok | output | 1 | Qualified acknowledge for the master logic |
| memr_ok | output | 1 | Read strobe not belonging to a refresh |
| in_refresh | output | 1 | Refresh phase tracker is outside its idle phase |
| refresh_seen | output | 1 | One-cycle pulse per completed refresh strobe |
| refresh_count | output | CNT_W | Wrapping count of refresh strobes |

## Verification
A change on ref_in, memr_in or dack_in reaches dack_ok, memr_ok, in_refresh and refresh_seen on the third rising edge. Two of those edges are spent in the synchroniser and one in the output register. A change on master_en reaches dack_ok on the first edge. The bench drives every input on a falling edge and counts falling edges from there. For the latency requirements it samples one edge early to confirm that the old value still holds, and then samples at the due edge. Because refresh_seen is a single-cycle pulse, it is checked in its due cycle and again one cycle later, when it must be low.

// File: rtl/dackf_pkg.sv
`timescale 1ns/1ps
package dackf_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned IN_W        = 3;
  localparam int unsigned IDX_REF     = 0;
  localparam int unsigned IDX_MEMR    = 1;
  localparam int unsigned IDX_DACK    = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } ref_phase_t;
endpackage

// File: rtl/dackf_rst_sync.sv
`timescale 1ns/1ps
module dackf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/dackf_sync.sv
`timescale 1ns/1ps
module dackf_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = d;
    end else begin : g_rest
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dackf_ack_gate.sv
`timescale 1ns/1ps
module dackf_ack_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic ref_s,
  input  logic dack_s,
  output logic dack_ok,
  output logic suppressed
);
  logic supp_q, supp_d;
  logic ok_q, ok_d;

  // Suppression latch: set by an acknowledge seen during refresh,
  // cleared by acknowledge release or by leaving bus-master mode.
  always_comb begin
    supp_d = supp_q;
    if (!master_en)  supp_d = 1'b0;
    else if (!dack_s) supp_d = 1'b0;
    else if (ref_s)   supp_d = 1'b1;
  end

  always_comb begin
    ok_d = master_en & dack_s & ~ref_s & ~supp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supp_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      supp_q <= supp_d;
      ok_q   <= ok_d;
    end
  end

  assign dack_ok    = ok_q;
  assign suppressed = supp_q;
endmodule

// File: rtl/dackf_ref_track.sv
`timescale 1ns/1ps
module dackf_ref_track
  import dackf_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  input  logic             memr_s,
  output logic             in_refresh,
  output logic             memr_ok,
  output logic             seen,
  output logic [CNT_W-1:0] count
);
  ref_phase_t       phase_q, phase_d;
  logic             seen_q, seen_d;
  logic             mok_q, mok_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    phase_d = phase_q;
    seen_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE:   if (ref_s) phase_d = PH_ADDR;
      PH_ADDR:   if (!ref_s) phase_d = PH_IDLE;
                 else if (memr_s) phase_d = PH_STROBE;
      PH_STROBE: if (!memr_s) begin
                   seen_d  = 1'b1;
                   phase_d = ref_s ? PH_HOLD : PH_IDLE;
                 end
      PH_HOLD:   if (!ref_s) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    mok_d  = memr_s & ~ref_s & (phase_q == PH_IDLE);
    cnt_en = seen_d;
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      seen_q  <= 1'b0;
      mok_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      seen_q  <= seen_d;
      mok_q   <= mok_d;
      cnt_q   <= cnt_d;
    end
  end

  assign in_refresh = (phase_q != PH_IDLE);
  assign memr_ok    = mok_q;
  assign seen       = seen_q;
  assign count      = cnt_q;
endmodule

// File: rtl/dma_ack_filter.sv
`timescale 1ns/1ps
module dma_ack_filter
  import dackf_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             ref_in,
  input  logic             memr_in,
  input  logic             dack_in,
  output logic             dack_ok,
  output logic             memr_ok,
  output logic             in_refresh,
  output logic             refresh_seen,
  output logic [CNT_W-1:0] refresh_count
);
  logic            srst_n;
  logic [IN_W-1:0] raw_in, sync_out;
  logic            ref_s, memr_s, dack_s;
  logic            supp;

  dackf_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_REF]  = ref_in;
    raw_in[IDX_MEMR] = memr_in;
    raw_in[IDX_DACK] = dack_in;
  end

  dackf_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(raw_in), .q(sync_out)
  );

  assign ref_s  = sync_out[IDX_REF];
  assign memr_s = sync_out[IDX_MEMR];
  assign dack_s = sync_out[IDX_DACK];

  dackf_ack_gate u_gate (
    .clk(clk), .rst_n(srst_n), .master_en(master_en),
    .ref_s(ref_s), .dack_s(dack_s),
    .dack_ok(dack_ok), .suppressed(supp)
  );

  dackf_ref_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(srst_n), .ref_s(ref_s), .memr_s(memr_s),
    .in_refresh(in_refresh), .memr_ok(memr_ok),
    .seen(refresh_seen), .count(refresh_count)
  );
endmodule

// File: rtl/dackf_chk.sv
`timescale 1ns/1ps
module dackf_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_en,
  input logic             ref_s,
  input logic             dack_s,
  input logic             supp,
  input logic             dack_ok,
  input logic             memr_ok,
  input logic             refresh_seen,
  input logic [CNT_W-1:0] refresh_count
);
  // R3
  ack_outside_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack_ok |-> $past(!ref_s && dack_s));

  // R4
  supp_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supp && dack_s && master_en) |=> supp);

  // R6
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!dack_ok && !supp));

  // R8
  seen_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_seen |=> !refresh_seen);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_seen |-> (refresh_count == CNT_W'($past(refresh_count) + 1'b1)));

  // R9
  memr_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memr_ok |-> $past(!ref_s));
endmodule

bind dma_ack_filter dackf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .master_en(master_en),
  .ref_s(ref_s), .dack_s(dack_s), .supp(supp),
  .dack_ok(dack_ok), .memr_ok(memr_ok),
  .refresh_seen(refresh_seen), .refresh_count(refresh_count)
);

// File: tb/tb_dma_ack_filter.sv
`timescale 1ns/1ps
module tb_dma_ack_filter;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, master_en, ref_in, memr_in, dack_in;
  logic dack_ok, memr_ok, in_refresh, refresh_seen;
  logic [CNT_W-1:0] refresh_count;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_ack_filter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .ref_in(ref_in), .memr_in(memr_in), .dack_in(dack_in),
    .dack_ok(dack_ok), .memr_ok(memr_ok), .in_refresh(in_refresh),
    .refresh_seen(refresh_seen), .refresh_count(refresh_count)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; master_en = 1'b1;
    ref_in = 1'b0; memr_in = 1'b0; dack_in = 1'b0;
    step(3);
    chk("R1", "dack_ok in reset", dack_ok, 0);
    chk("R1", "in_refresh in reset", in_refresh, 0);
    rst_n = 1'b1;
    step(4);
    chk("R1", "dack_ok", dack_ok, 0);
    chk("R1", "memr_ok", memr_ok, 0);
    chk("R1", "refresh_seen", refresh_seen, 0);
    chk("R1", "refresh_count", refresh_count, 0);
  endtask

  task automatic t_plain_ack;
    dack_in = 1'b1;
    step(2); chk("R2", "ack not early", dack_ok, 0);
    step(1); chk("R2", "ack at 3 edges", dack_ok, 1);
    dack_in = 1'b0;
    step(2); chk("R2", "release not early", dack_ok, 1);
    step(1); chk("R2", "release at 3 edges", dack_ok, 0);
    step(2);
  endtask

  task automatic t_ack_in_refresh;
    ref_in = 1'b1; step(3);
    dack_in = 1'b1; step(4);
    chk("R3", "ack during refresh", dack_ok, 0);
    ref_in = 1'b0; step(5);
    chk("R3", "ack held after refresh end", dack_ok, 0);
    dack_in = 1'b0; step(4);
    dack_in = 1'b1; step(3);
    chk("R5", "fresh ack after release", dack_ok, 1);
    dack_in = 1'b0; step(4);
  endtask

  task automatic t_ref_over_ack;
    dack_in = 1'b1; step(3);
    chk("R4", "ack before refresh", dack_ok, 1);
    ref_in = 1'b1; step(3);
    chk("R4", "ack dropped by refresh", dack_ok, 0);
    ref_in = 1'b0; step(5);
    chk("R4", "ack stays blocked", dack_ok, 0);
    dack_in = 1'b0; step(4);
    dack_in = 1'b1; step(3);
    chk("R5", "ack returns", dack_ok, 1);
    dack_in = 1'b0; step(4);
  endtask

  task automatic t_master_off;
    dack_in = 1'b1; step(3);
    chk("R6", "ack with master on", dack_ok, 1);
    master_en = 1'b0; step(1);
    chk("R6", "ack forced low", dack_ok, 0);
    master_en = 1'b1; step(1);
    chk("R6", "ack back on enable", dack_ok, 1);
    // suppression cleared by disable
    ref_in = 1'b1; step(4); ref_in = 1'b0; step(4);
    chk("R6", "suppressed before disable", dack_ok, 0);
    master_en = 1'b0; step(1);
    master_en = 1'b1; step(1);
    chk("R6", "suppression cleared", dack_ok, 1);
    dack_in = 1'b0; step(4);
  endtask

  task automatic t_refresh(input logic [CNT_W-1:0] exp_cnt);
    ref_in = 1'b1;
    step(2); chk("R7", "in_refresh not early", in_refresh, 0);
    step(1); chk("R7", "in_refresh at 3 edges", in_refresh, 1);
    memr_in = 1'b1; step(4);
    chk("R9", "strobe inside refresh", memr_ok, 0);
    memr_in = 1'b0;
    step(2); chk("R8", "seen not early", refresh_seen, 0);
    step(1); chk("R8", "seen pulse", refresh_seen, 1);
    chk("R8", "count step", refresh_count, exp_cnt);
    step(1); chk("R8", "seen one cycle", refresh_seen, 0);
    ref_in = 1'b0;
    step(2); chk("R7", "in_refresh hold", in_refresh, 1);
    step(1); chk("R7", "in_refresh off", in_refresh, 0);
    step(2);
  endtask

  task automatic t_plain_read;
    memr_in = 1'b1;
    step(2); chk("R9", "read not early", memr_ok, 0);
    step(1); chk("R9", "read at 3 edges", memr_ok, 1);
    chk("R8", "no refresh pulse", refresh_seen, 0);
    memr_in = 1'b0; step(3);
    chk("R9", "read released", memr_ok, 0);
    chk("R8", "count unchanged", refresh_count, 2);
    step(2);
  endtask

  initial begin
    t_reset();
    t_plain_ack();
    t_ack_in_refresh();
    t_ref_over_ack();
    t_master_off();
    t_refresh(8'd1);
    t_refresh(8'd2);
    t_plain_read();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule